// File: doc/BRIEF.md
# Low-Speed Sleep Mode Controller

This block manages one power mode of a small microcontroller. While the core runs from the low-speed clock, a sleep-instruction strobe moves the system into a low-speed sleep state. The move happens only when three configuration bits agree: standby select is cleared, the low-speed enable is set and the timer clock-source select is set. In sleep the controller stops the core clock and the clocks of the A/D converter and the PWM unit. The clocks of all other peripherals keep running, so that timers, the serial port and the event counter can still raise interrupts.

Each interrupt request is resynchronised to the low-speed clock by a two-stage register chain. A synchronised request wakes the system only if its per-source enable bit is set and the global mask bit is clear. The wake passes through a one-cycle waking state. In that state the controller emits an exception-start pulse and then returns to the active state. An active-low asynchronous reset forces the controller back to the active state at any time. The controller never resets any register outside itself, so register and I/O state outside the block is left unchanged across sleep.

Top module: `lp_sleep_ctrl`

## Requirements
- R1: In the active state, a sleep strobe with cfg_stby_sel=0, cfg_lowspd_on=1 and cfg_tmr_src=1 moves mode to sleep at the next rising edge.
- R2: A sleep strobe with any of those three bits at the wrong value is ignored: mode stays active and the clocks stay enabled.
- R3: core_clk_en, adc_clk_en and pwm_clk_en are 0 exactly while mode is sleep, and 1 in every other mode.
- R4: While asleep, a request whose enable bit is 0, or any request while irq_mask=1, leaves mode at sleep.
- R5: With the default two-stage synchroniser, an enabled and unmasked request first sampled at rising edge E0 puts mode at waking and raises exc_start from edge E2.
- R6: exc_start lasts exactly one cycle, and mode is active at the edge after it rises.
- R7: If an enabled and unmasked synchronised request is pending when a valid sleep strobe arrives, sleep is not entered.
- R8: rst_n low forces mode to active and all clock enables to 1 asynchronously, including from sleep.
- R9: mode is encoded as 0 for active, 1 for sleep and 2 for waking, and never takes the value 3.
- R10: Every one of the NSRC (default 16, at least 12) request lines can wake the block on its own.
- R11: exc_start only follows sleep. A request in the active state produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Sleep instruction strobe |
| cfg_stby_sel | input | 1 | Standby select; must be 0 for this mode |
| cfg_lowspd_on | input | 1 | Low-speed enable; must be 1 |
| cfg_tmr_src | input | 1 | Timer clock-source select; must be 1 |
| irq_req | input | NSRC | Raw interrupt requests |
| irq_en | input | NSRC | Per-source interrupt enables |
| irq_mask | input | 1 | Global interrupt mask (1 = masked) |
| core_clk_en | output | 1 | Core clock enable |
| adc_clk_en | output | 1 | A/D converter clock enable |
| pwm_clk_en | output | 1 | PWM clock enable |
| exc_start | output | 1 | One-cycle exception-start pulse |
| mode | output | 2 | Current mode code |

## Verification
The hardest case to reach is a request that is already synchronised and enabled at the moment the sleep strobe arrives. To set it up, the stimulus holds a request high for several cycles in the active state, so that both synchroniser stages fill. Only then does it pulse a valid strobe. Wake latency is measured by raising a request just after a falling edge and counting rising edges up to the pulse. Each request line is also swept one at a time through a full sleep and wake cycle.

// File: rtl/lp_sleep_ctrl.sv
module lp_sleep_ctrl #(
  parameter int NSRC       = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_req,
  input  logic            cfg_stby_sel,
  input  logic            cfg_lowspd_on,
  input  logic            cfg_tmr_src,
  input  logic [NSRC-1:0] irq_req,
  input  logic [NSRC-1:0] irq_en,
  input  logic            irq_mask,
  output logic            core_clk_en,
  output logic            adc_clk_en,
  output logic            pwm_clk_en,
  output logic            exc_start,
  output logic [1:0]      mode
);
  typedef enum logic [1:0] {M_ACTIVE = 2'd0, M_SLEEP = 2'd1, M_WAKE = 2'd2} mode_t;

  mode_t           state;
  logic [NSRC-1:0] sync_q [SYNC_DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_DEPTH; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= irq_req;
      for (int i = 1; i < SYNC_DEPTH; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  wire entry_ok = !cfg_stby_sel && cfg_lowspd_on && cfg_tmr_src;
  wire wake_hit = !irq_mask && |(sync_q[SYNC_DEPTH-1] & irq_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= M_ACTIVE;
    else begin
      case (state)
        M_ACTIVE: if (sleep_req && entry_ok && !wake_hit) state <= M_SLEEP;
        M_SLEEP:  if (wake_hit) state <= M_WAKE;
        M_WAKE:   state <= M_ACTIVE;
        default:  state <= M_ACTIVE;
      endcase
    end
  end

  wire asleep = (state == M_SLEEP);
  assign core_clk_en = !asleep;
  assign adc_clk_en  = !asleep;
  assign pwm_clk_en  = !asleep;
  assign exc_start   = (state == M_WAKE);
  assign mode        = state;

  assert_enter_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && sleep_req && !cfg_stby_sel && cfg_lowspd_on && cfg_tmr_src
     && !(!irq_mask && |(sync_q[SYNC_DEPTH-1] & irq_en))) |=> mode == 2'd1);

  assert_bad_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !(!cfg_stby_sel && cfg_lowspd_on && cfg_tmr_src)) |=> mode != 2'd1);

  assert_clk_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_clk_en) |-> $past(mode) == 2'd0 && $past(sleep_req));

  assert_stay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && (irq_mask || (sync_q[SYNC_DEPTH-1] & irq_en) == '0)) |=> mode == 2'd1);

  assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_start |=> !exc_start && mode == 2'd0);

  assert_no_enter_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !irq_mask && |(sync_q[SYNC_DEPTH-1] & irq_en)) |=> mode == 2'd0);

  assert_mode_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);

  assert_from_sleep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exc_start) |-> $past(mode) == 2'd1);
endmodule

// File: tb/tb_lp_sleep_ctrl.sv
module tb_lp_sleep_ctrl;
  localparam int N = 16;
  logic clk = 0, rst_n = 0;
  logic sleep_req = 0, cfg_stby_sel = 0, cfg_lowspd_on = 1, cfg_tmr_src = 1;
  logic [N-1:0] irq_req = '0, irq_en = '0;
  logic irq_mask = 0;
  logic core_clk_en, adc_clk_en, pwm_clk_en, exc_start;
  logic [1:0] mode;
  int checks = 0, errors = 0;

  lp_sleep_ctrl #(.NSRC(N), .SYNC_DEPTH(2)) dut (.*);

  always #5 clk = ~clk;

  // behavioural reference: queue models the synchroniser delay
  logic [N-1:0] dq[$] = '{'0, '0};
  int ref_mode = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq = '{'0, '0}; ref_mode = 0;
    end else begin
      bit hit;
      hit = !irq_mask && ((dq[0] & irq_en) != 0);
      if (ref_mode == 0) begin
        if (sleep_req && !cfg_stby_sel && cfg_lowspd_on && cfg_tmr_src && !hit) ref_mode = 1;
      end else if (ref_mode == 1) begin
        if (hit) ref_mode = 2;
      end else ref_mode = 0;
      void'(dq.pop_front());
      dq.push_back(irq_req);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk(mode == 2'(ref_mode), "R9 mode vs model", mode, ref_mode);
    chk(exc_start == (ref_mode == 2), "R6 exc_start vs model", exc_start, ref_mode == 2);
    chk({core_clk_en, adc_clk_en, pwm_clk_en} == {3{ref_mode != 1}}, "R3 clock enables vs model",
        {core_clk_en, adc_clk_en, pwm_clk_en}, {3{ref_mode != 1}});
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    sleep_req = 1; cyc(1); sleep_req = 0;
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(2);
    chk(mode == 0 && core_clk_en && adc_clk_en && pwm_clk_en, "R8 reset state", mode, 0);
    rst_n = 1; cyc(2);
    // R2: each wrong configuration bit
    cfg_stby_sel = 1; strobe(); chk(mode == 0 && core_clk_en, "R2 stby_sel=1 ignored", mode, 0); cfg_stby_sel = 0;
    cfg_lowspd_on = 0; strobe(); chk(mode == 0, "R2 lowspd_on=0 ignored", mode, 0); cfg_lowspd_on = 1;
    cfg_tmr_src = 0; strobe(); chk(mode == 0, "R2 tmr_src=0 ignored", mode, 0); cfg_tmr_src = 1;
    // R1 entry
    strobe();
    chk(mode == 1, "R1 enter sleep", mode, 1);
    chk(!core_clk_en && !adc_clk_en && !pwm_clk_en, "R3 clocks gated in sleep", core_clk_en, 0);
    // R4 disabled source and masked source
    irq_en = 16'h0001; irq_req = 16'h0002; cyc(4);
    chk(mode == 1, "R4 disabled source keeps sleep", mode, 1);
    irq_mask = 1; irq_req = 16'h0001; cyc(4);
    chk(mode == 1, "R4 masked request keeps sleep", mode, 1);
    irq_req = '0; cyc(3); irq_mask = 0;
    // R5 latency
    irq_req = 16'h0001;
    @(posedge clk); @(posedge clk); #1;
    chk(mode == 1 && !exc_start, "R5 no pulse before E2", mode, 1);
    @(posedge clk); #1;
    chk(mode == 2 && exc_start, "R5 pulse at E2", mode, 2);
    @(posedge clk); #1;
    chk(mode == 0 && !exc_start, "R6 single pulse then active", mode, 0);
    irq_req = '0; cyc(3);
    // R10 each source
    for (int i = 0; i < N; i++) begin
      irq_en = '0; irq_en[i] = 1'b1;
      strobe();
      chk(mode == 1, "R10 sleep before source wake", mode, 1);
      irq_req = '0; irq_req[i] = 1'b1; cyc(3);
      chk(mode == 2 && exc_start, $sformatf("R10 source %0d wakes", i), mode, 2);
      irq_req = '0; cyc(3);
    end
    // R7 pending interrupt blocks entry
    irq_en = 16'h0100; irq_req = 16'h0100; cyc(3);
    chk(mode == 0 && !exc_start, "R11 request in active gives no pulse", exc_start, 0);
    strobe(); cyc(1);
    chk(mode == 0, "R7 pending request blocks entry", mode, 0);
    irq_req = '0; cyc(3);
    // R8 async reset from sleep
    strobe(); chk(mode == 1, "R1 re-enter sleep", mode, 1);
    #2 rst_n = 0; #1;
    chk(mode == 0 && core_clk_en, "R8 async reset clears sleep", mode, 0);
    cyc(1); rst_n = 1; cyc(2);
    chk(mode == 0, "R8 active after reset release", mode, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule